// File: doc/BRIEF.md
# ECC Single-Bit Error Logger

The logger sits on the read-return path of a DRAM controller and records where the first correctable single-bit error was found. A read transfer is announced by a start strobe that carries the effective DRAM quadword address and the transfer length. One to four 64-bit quadword beats then follow. Each beat comes with one error flag per 32-bit dword half, raised by the ECC checker upstream.

When error correction is enabled, the first flagged beat is written into a 32-bit log word and a valid flag is raised. The log word holds three fields: the effective quadword address of the transfer, the position of the beat within the transfer, and which dword half was in error. Software reads the word, converts the address back to a physical one by its own means, and pulses a clear input to re-arm the logger. Errors that arrive while the log is valid are ignored.

Top module: `ecclog_top`

## Requirements
- R1: After reset, `log_word` is 0 and `log_valid` is 0.
- R2: `log_word[31:3]` holds the `burst_addr` value presented with the start strobe of the transfer in which the logged error occurred.
- R3: `log_word[2:1]` holds the beat position counted in arrival order: 0 for the first beat after the start strobe, then 1, 2 and 3. The low bits of the address have no effect on it.
- R4: When `burst_len` is 0, the transfer is a single quadword, and `log_word[2:1]` is recorded as 00 for any beat of that transfer.
- R5: `log_word[0]` is 1 when the logged beat flagged only `beat_err[1]` (upper dword) and 0 when it flagged `beat_err[0]` (lower dword). When both are flagged, the lower dword is logged and the bit is 0.
- R6: While `corr_en` is 0, a flagged beat does not change `log_word` or `log_valid`.
- R7: While `log_valid` is 1, later flagged beats leave `log_word` unchanged, unless `sw_clear` is also high in that cycle.
- R8: A `sw_clear` pulse with no qualifying flagged beat in that cycle sets `log_word` to 0 and `log_valid` to 0 on the next cycle.
- R9: When `sw_clear` and a qualifying flagged beat fall in the same cycle, the new error is captured and `log_valid` stays 1.
- R10: A beat presented in the same cycle as the start strobe is beat 0 of the new transfer and uses the new address.
- R11: The beat position saturates at 3. Beats after the fourth one of a transfer log position 3.
- R12: `log_word` and `log_valid` are registers and change one clock edge after the qualifying input cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Start strobe of a read transfer |
| burst_addr | input | 29 | Effective DRAM quadword address of the transfer |
| burst_len | input | 2 | Number of beats minus one |
| beat_valid | input | 1 | A quadword beat is present |
| beat_err | input | 2 | Single-bit error flag per dword: bit 0 lower, bit 1 upper |
| corr_en | input | 1 | Single-bit correction enabled; logging works only when high |
| sw_clear | input | 1 | Software clear of the log |
| log_word | output | 32 | {address[28:0], beat position[1:0], upper-dword flag} |
| log_valid | output | 1 | The log holds a captured error |

## Verification
Two events can land on the same cycle. The first pair is a software clear and a new qualifying error, which together must leave a fresh capture and a set valid flag (R9). The second pair is a start strobe and a beat, where the beat must be tagged as position 0 with the new address (R10). Directed steps provoke each pair on its own, with expected words written out in full. The random phase raises clears, starts and flagged beats independently, so these pairs also collide at arbitrary beat positions. There, every cycle is judged against a bench model built from the requirements.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  // Default geometry of the logger
  localparam int unsigned LOG_ADDR_W   = 29; // quadword address width
  localparam int unsigned LOG_MAX_BEAT = 4;  // longest transfer in beats
  localparam int unsigned LOG_DW_PER_QW = 2; // dword halves per beat

  // Index of the lowest set flag; the lower dword wins a tie
  function automatic int unsigned lowest_flag(input logic [31:0] flags, input int unsigned n);
    int unsigned pos;
    pos = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && flags[i]) pos = i;
    end
    return pos;
  endfunction
endpackage

// File: rtl/ecclog_beat_track.sv
module ecclog_beat_track #(
  parameter int unsigned ADDR_W    = 29,
  parameter int unsigned MAX_BEATS = 4,
  localparam int unsigned IDX_W    = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] burst_addr,
  input  logic [IDX_W-1:0]  burst_len,
  input  logic              beat_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_single
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_BEATS - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              single_q;

  // Context of the beat in this cycle; a start strobe takes effect at once
  always_comb begin
    if (burst_start) begin
      cur_addr   = burst_addr;
      cur_idx    = '0;
      cur_single = (burst_len == '0);
    end else begin
      cur_addr   = addr_q;
      cur_idx    = cnt_q;
      cur_single = single_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      single_q <= 1'b0;
    end else if (burst_start) begin
      addr_q   <= burst_addr;
      single_q <= (burst_len == '0);
      cnt_q    <= beat_valid ? IDX_W'(1) : '0;
    end else if (beat_valid && cnt_q != LAST_IDX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R11: the position stays at its ceiling once reached
  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (!burst_start && cnt_q == LAST_IDX) |=> (cnt_q == LAST_IDX || $past(rst)))
    else $error("beat position left its ceiling");

  // R10: a start strobe without a beat re-arms the position at zero
  p_start_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (burst_start && !beat_valid) |=> (cnt_q == '0))
    else $error("start strobe did not reset the beat position");
endmodule

// File: rtl/ecclog_half_pick.sv
module ecclog_half_pick #(
  parameter int unsigned DW_PER_QW = 2,
  localparam int unsigned HALF_W   = $clog2(DW_PER_QW)
) (
  input  logic [DW_PER_QW-1:0] beat_err,
  output logic                 any_err,
  output logic [HALF_W-1:0]    half_sel
);
  logic [31:0] flags_wide;

  always_comb begin
    flags_wide = 32'(beat_err);
    any_err    = |beat_err;
    half_sel   = HALF_W'(ecclog_pkg::lowest_flag(flags_wide, DW_PER_QW));
  end

  // R5: the chosen half is always one that actually flagged
  a_half_flagged_r5: assert final (!any_err || beat_err[half_sel])
    else $error("picked a dword half that has no error flag");
endmodule

// File: rtl/ecclog_capture.sv
module ecclog_capture #(
  parameter int unsigned LOG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cand_valid,
  input  logic [LOG_W-1:0] cand_word,
  input  logic             sw_clear,
  output logic [LOG_W-1:0] log_word,
  output logic             log_valid
);
  logic take;
  assign take = cand_valid && (!log_valid || sw_clear);

  always_ff @(posedge clk) begin
    if (rst) begin
      log_word  <= '0;
      log_valid <= 1'b0;
    end else if (take) begin
      log_word  <= cand_word;
      log_valid <= 1'b1;
    end else if (sw_clear) begin
      log_word  <= '0;
      log_valid <= 1'b0;
    end
  end

  // R7: a held log is untouched unless software clears it
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (log_valid && !sw_clear) |=> ($stable(log_word) && log_valid))
    else $error("held log changed");

  // R8: a lone clear empties the log
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && !cand_valid) |=> (!log_valid && log_word == '0))
    else $error("clear did not empty the log");

  // R9: clear and new error together keep a valid capture
  p_clear_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && cand_valid) |=> (log_valid && log_word == $past(cand_word)))
    else $error("coincident error lost on clear");
endmodule

// File: rtl/ecclog_top.sv
module ecclog_top #(
  parameter int unsigned ADDR_W    = ecclog_pkg::LOG_ADDR_W,
  parameter int unsigned MAX_BEATS = ecclog_pkg::LOG_MAX_BEAT,
  parameter int unsigned DW_PER_QW = ecclog_pkg::LOG_DW_PER_QW,
  localparam int unsigned IDX_W    = $clog2(MAX_BEATS),
  localparam int unsigned HALF_W   = $clog2(DW_PER_QW),
  localparam int unsigned LOG_W    = ADDR_W + IDX_W + HALF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 burst_start,
  input  logic [ADDR_W-1:0]    burst_addr,
  input  logic [IDX_W-1:0]     burst_len,
  input  logic                 beat_valid,
  input  logic [DW_PER_QW-1:0] beat_err,
  input  logic                 corr_en,
  input  logic                 sw_clear,
  output logic [LOG_W-1:0]     log_word,
  output logic                 log_valid
);
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_single;
  logic              any_err;
  logic [HALF_W-1:0] half_sel;
  logic [IDX_W-1:0]  idx_eff;
  logic              cand_valid;
  logic [LOG_W-1:0]  cand_word;

  ecclog_beat_track #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) u_track (
    .clk(clk), .rst(rst), .burst_start(burst_start), .burst_addr(burst_addr),
    .burst_len(burst_len), .beat_valid(beat_valid), .cur_addr(cur_addr),
    .cur_idx(cur_idx), .cur_single(cur_single));

  ecclog_half_pick #(.DW_PER_QW(DW_PER_QW)) u_pick (
    .beat_err(beat_err), .any_err(any_err), .half_sel(half_sel));

  always_comb begin
    idx_eff    = cur_single ? '0 : cur_idx;
    cand_valid = beat_valid && any_err && corr_en;
    cand_word  = {cur_addr, idx_eff, half_sel};
  end

  ecclog_capture #(.LOG_W(LOG_W)) u_cap (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_word(cand_word),
    .sw_clear(sw_clear), .log_word(log_word), .log_valid(log_valid));

  // R6: with correction off, an empty log stays empty
  p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (!corr_en && !log_valid) |=> !log_valid)
    else $error("capture while correction disabled");

  // R4: a single-quadword transfer logs position 00
  p_single_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && cur_single && (!log_valid || sw_clear))
      |=> (log_word[IDX_W+HALF_W-1:HALF_W] == '0))
    else $error("single-quadword capture with nonzero position");

  // R1: reset empties the log
  p_reset_r1: assert property (@(posedge clk) rst |=> (!log_valid && log_word == '0))
    else $error("log not empty after reset");
endmodule

// File: tb/sim_ecclog_top.sv
`timescale 1ns/1ps
module sim_ecclog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_start = 1'b0;
  logic [28:0] burst_addr = '0;
  logic [1:0]  burst_len = '0;
  logic        beat_valid = 1'b0;
  logic [1:0]  beat_err = '0;
  logic        corr_en = 1'b1;
  logic        sw_clear = 1'b0;
  logic [31:0] log_word;
  logic        log_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [28:0] m_addr = '0;
  logic [1:0]  m_cnt = '0;
  logic        m_single = 1'b0;
  logic [31:0] m_word = '0;
  logic        m_valid = 1'b0;

  always #2 clk = ~clk;

  ecclog_top u0 (
    .clk(clk), .rst(rst), .burst_start(burst_start), .burst_addr(burst_addr),
    .burst_len(burst_len), .beat_valid(beat_valid), .beat_err(beat_err),
    .corr_en(corr_en), .sw_clear(sw_clear), .log_word(log_word), .log_valid(log_valid));

  function automatic logic [31:0] exp_word(input logic [28:0] a, input logic [1:0] i, input logic up);
    return {a, i, up};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model step from the requirements, applied for the inputs of the cycle just clocked
  task automatic model_step();
    logic [1:0]  idx;
    logic [28:0] a;
    logic        sgl;
    logic        hit;
    idx = burst_start ? 2'd0 : m_cnt;
    a   = burst_start ? burst_addr : m_addr;
    sgl = burst_start ? (burst_len == 2'd0) : m_single;
    hit = beat_valid && (beat_err != 2'b00) && corr_en;
    if (hit && (!m_valid || sw_clear)) begin
      m_word  = exp_word(a, sgl ? 2'd0 : idx, beat_err[0] ? 1'b0 : 1'b1);
      m_valid = 1'b1;
    end else if (sw_clear) begin
      m_word  = '0;
      m_valid = 1'b0;
    end
    if (rst) begin
      m_addr = '0; m_cnt = '0; m_single = 1'b0; m_word = '0; m_valid = 1'b0;
    end else if (burst_start) begin
      m_addr = burst_addr; m_single = (burst_len == 2'd0); m_cnt = beat_valid ? 2'd1 : 2'd0;
    end else if (beat_valid && m_cnt != 2'd3) begin
      m_cnt = m_cnt + 2'd1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    burst_start = 1'b0; beat_valid = 1'b0; beat_err = 2'b00; sw_clear = 1'b0;
  endtask

  task automatic start(input logic [28:0] a, input logic [1:0] len, input logic bv, input logic [1:0] e);
    burst_start = 1'b1; burst_addr = a; burst_len = len; beat_valid = bv; beat_err = e;
    tick();
  endtask

  task automatic beat(input logic [1:0] e, input logic clr);
    beat_valid = 1'b1; beat_err = e; sw_clear = clr;
    tick();
  endtask

  task automatic clear();
    sw_clear = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 word", log_word, 32'h0);
    check("R1 valid", {31'b0, log_valid}, 32'h1 & 32'h0);

    // R6 correction disabled
    corr_en = 1'b0;
    start(29'h0000AB1, 2'd3, 1'b1, 2'b01);
    beat(2'b10, 1'b0);
    check("R6 valid", {31'b0, log_valid}, 32'h0);
    check("R6 word", log_word, 32'h0);
    corr_en = 1'b1;

    // R2 R3 R5 wrapped-start transfer, error in upper half of third beat
    start(29'h0123457, 2'd3, 1'b0, 2'b00);
    beat(2'b00, 1'b0);
    beat(2'b00, 1'b0);
    beat(2'b10, 1'b0);
    check("R2/R3/R5 word", log_word, exp_word(29'h0123457, 2'd2, 1'b1));
    check("R12 valid", {31'b0, log_valid}, 32'h1);

    // R7 later error is ignored
    beat(2'b01, 1'b0);
    start(29'h1FFFFFF, 2'd1, 1'b1, 2'b11);
    check("R7 retain", log_word, exp_word(29'h0123457, 2'd2, 1'b1));

    // R8 clear
    clear();
    check("R8 word", log_word, 32'h0);
    check("R8 valid", {31'b0, log_valid}, 32'h0);

    // R10 beat with start strobe, both halves flagged (R5 tie)
    start(29'h0F0F0F3, 2'd1, 1'b1, 2'b11);
    check("R10/R5 word", log_word, exp_word(29'h0F0F0F3, 2'd0, 1'b0));

    // R9 clear and new error in the same cycle
    beat(2'b01, 1'b1);
    check("R9 word", log_word, exp_word(29'h0F0F0F3, 2'd1, 1'b0));
    check("R9 valid", {31'b0, log_valid}, 32'h1);

    // R11 saturation past the fourth beat
    clear();
    start(29'h1234560, 2'd3, 1'b0, 2'b00);
    for (int i = 0; i < 5; i++) beat(2'b00, 1'b0);
    beat(2'b10, 1'b0);
    check("R11 word", log_word, exp_word(29'h1234560, 2'd3, 1'b1));

    // R4 single-quadword transfer, error on an extra beat
    clear();
    start(29'h0000042, 2'd0, 1'b1, 2'b00);
    beat(2'b10, 1'b0);
    check("R4 word", log_word, exp_word(29'h0000042, 2'd0, 1'b1));

    // R5 lower-only half
    clear();
    start(29'h0ABCDEF, 2'd2, 1'b0, 2'b00);
    beat(2'b00, 1'b0);
    beat(2'b01, 1'b0);
    check("R5 lower", log_word, exp_word(29'h0ABCDEF, 2'd1, 1'b0));

    // Random phase checked against the model every cycle (R2 R3 R7 R9 R10)
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom();
      burst_start = (r[3:0] == 4'd0);
      burst_addr  = 29'($urandom());
      burst_len   = r[5:4];
      beat_valid  = r[6] | r[7];
      beat_err    = (r[10:8] == 3'd0) ? r[12:11] : 2'b00;
      corr_en     = (r[15:13] != 3'd0);
      sw_clear    = (r[20:16] == 5'd0);
      tick();
      check("R7 model word", log_word, m_word);
      check("R7 model valid", {31'b0, log_valid}, {31'b0, m_valid});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule